// File: doc/BRIEF.md
# MDIO Management Master

This block is a station-management master for the two-wire PHY management bus. It produces the management clock by dividing the system clock. It drives the shared data line through an output value and an output enable meant for a tri-state pad, and reads the line back through a separate input. It carries out single register reads and writes to a PHY.

A transaction starts when the caller presents a request while the block is idle. The request gives the direction, a flag for the extended (Clause 45) addressing scheme, a 5-bit PHY address, a 21-bit address and 16 bits of write data.

- **Clause 22 request.** Only address bits 4:0 are used, as the register number.
- **Clause 45 request.** Bits 20:16 select the device and bits 15:0 select the register. The block first sends an address frame and then the read or write frame.

Each frame begins with a run of ones. It then carries start and opcode bits, the PHY and register/device fields, and a turnaround and 16 data bits. When the transaction ends, the block pulses `done`. It returns the read data and an error flag, and both stay valid until the next completion.

On a read the block checks the turnaround bit that the PHY drives. If that bit is high, the block treats the PHY as absent and clocks the bus to flush it, then reports all ones with the error flag set. A 32-bit per-PHY mask lets the caller exempt PHYs whose turnaround is known to misbehave.

Top module: `mdio_master`

## Requirements
- R1: After synchronous reset, and whenever no transaction runs, `busy` and `done` are low, `mdc` is low and `mdio_oe` is low.
- R2: Each bit slot on the bus is `HALF_CYC` system cycles with `mdc` low, followed by `HALF_CYC` cycles with `mdc` high. The first slot begins the cycle after the request is accepted.
- R3: Every frame opens with 32 driven slots carrying 1.
- R4: In a Clause 22 frame, the 32 ones are followed by these bits, each field most significant bit first:
  - the start bits 0,1;
  - the opcode, 1,0 for a read or 0,1 for a write;
  - `req_phy`;
  - `req_addr[4:0]`.
- R5: For a write frame, and for a Clause 45 address frame, the block drives a turnaround of 1 then 0, then 16 data bits MSB first. It then releases the line for one idle slot, and `done` follows that slot.
- R6: A Clause 45 request sends two frames, both with start bits 0,0 and `req_addr[20:16]` in the 5-bit field.
  - The first frame is an address frame with opcode 0,0 and a payload of `req_addr[15:0]`.
  - The second frame uses opcode 1,1 for a read or 0,1 for a write.
- R7: For a read frame, the block releases the line after the 5-bit field and samples the turnaround in the next slot.
  - If the turnaround is low, it shifts in 16 data bits MSB first, one per slot, each sampled in the last system cycle of the `mdc` high half.
  - After one idle slot it completes with that data in `rd_data` and `err` low.
- R8: If the sampled turnaround is high and `ta_ignore_mask[req_phy]` is 0, the block clocks 32 more released slots. It then completes with `rd_data` = 0xFFFF and `err` high.
- R9: If the sampled turnaround is high and `ta_ignore_mask[req_phy]` is 1, the high turnaround is ignored. The read proceeds as in R7 with `err` low.
- R10: `mdio_oe` and `mdio_out` change only at the start of a slot's low half. They are steady while `mdc` is high.
- R11: `busy` is high from the cycle after acceptance until the completion cycle. Requests presented while busy have no effect on the bus or on the results.
- R12: `done` is a single-cycle pulse in the cycle `busy` falls. `rd_data` and `err` hold their values until the next completion, and a write leaves `rd_data` unchanged and clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present; taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_c45 | input | 1 | Use Clause 45 address-then-access sequence |
| req_phy | input | 5 | PHY address |
| req_addr | input | 21 | Register (Clause 22: bits 4:0) or device[20:16]/register[15:0] |
| req_wdata | input | 16 | Write data |
| ta_ignore_mask | input | 32 | Per-PHY bit: ignore a high read turnaround |
| mdio_in | input | 1 | Data line as seen at the pad |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result (0xFFFF on failed turnaround) |
| err | output | 1 | Turnaround failure on the last completed access |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line value to drive |
| mdio_oe | output | 1 | Data line output enable |

## Verification
The bench predicts the expected level of `mdc`, `mdio_oe` and `mdio_out` for every system cycle of every frame, and acts as the PHY by driving `mdio_in` slot by slot.

- **Frame layout.** A design that miscounts the preamble or orders a field LSB first shifts or mirrors the bit stream and is caught at once. So is one that skips or reorders the Clause 45 address frame.
- **Turnaround handling.** A high turnaround is applied both with the PHY's mask bit clear and with it set. A design that flushes the wrong number of slots, or misses the flush, returns at the wrong cycle or with the wrong data and error flag. So does one that consults the wrong mask bit.
- **Busy and completion.** Spurious requests are raised mid-transaction, which exposes a design that accepts while busy. A write after a read checks that results are held rather than cleared.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_CYC = 13
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_c45,
  input  logic [4:0]  req_phy,
  input  logic [20:0] req_addr,
  input  logic [15:0] req_wdata,
  input  logic [31:0] ta_ignore_mask,
  input  logic        mdio_in,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        err,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_CYC - 1);
  localparam logic [6:0] WR_LEN = 7'd64;
  localparam logic [6:0] RD_LEN = 7'd46;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_XFER, S_FLUSH} st_t;

  st_t         st;
  logic        ph;
  logic [CW-1:0] cnt;
  logic [6:0]  idx;
  logic        wr, c45;
  logic [4:0]  phy;
  logic [20:0] addr;
  logic [15:0] wdata, rsh;

  logic        tick, slot_end, rd_frame;
  logic [1:0]  start_bits, op_bits;
  logic [4:0]  regf;
  logic [15:0] payload;
  logic [63:0] frame;
  logic [6:0]  drive_len;

  assign tick       = (cnt == CNT_LAST);
  assign slot_end   = (st != S_IDLE) && ph && tick;
  assign rd_frame   = (st == S_XFER) && !wr;
  assign start_bits = c45 ? 2'b00 : 2'b01;
  assign op_bits    = (st == S_ADDR) ? 2'b00 :
                      wr             ? 2'b01 :
                      c45            ? 2'b11 : 2'b10;
  assign regf       = c45 ? addr[20:16] : addr[4:0];
  assign payload    = (st == S_ADDR) ? addr[15:0] : wdata;
  assign frame      = {32'hFFFF_FFFF, start_bits, op_bits, phy, regf, 2'b10, payload};
  assign drive_len  = rd_frame ? RD_LEN : WR_LEN;

  assign busy     = (st != S_IDLE);
  assign mdc      = ph;
  assign mdio_oe  = ((st == S_ADDR) || (st == S_XFER)) && (idx < drive_len);
  assign mdio_out = mdio_oe && frame[6'd63 - idx[5:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      ph      <= 1'b0;
      cnt     <= '0;
      idx     <= '0;
      wr      <= 1'b0;
      c45     <= 1'b0;
      phy     <= '0;
      addr    <= '0;
      wdata   <= '0;
      rsh     <= '0;
      rd_data <= '0;
      err     <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        cnt <= '0;
        ph  <= 1'b0;
        if (req_valid) begin
          wr    <= req_write;
          c45   <= req_c45;
          phy   <= req_phy;
          addr  <= req_addr;
          wdata <= req_wdata;
          idx   <= '0;
          st    <= req_c45 ? S_ADDR : S_XFER;
        end
      end else begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) ph <= ~ph;
        if (slot_end) begin
          idx <= idx + 7'd1;
          case (st)
            S_ADDR: if (idx == WR_LEN) begin
              st  <= S_XFER;
              idx <= '0;
            end
            S_XFER: begin
              if (wr) begin
                if (idx == WR_LEN) begin
                  st   <= S_IDLE;
                  done <= 1'b1;
                  err  <= 1'b0;
                end
              end else if (idx == RD_LEN) begin
                if (mdio_in && !ta_ignore_mask[phy]) begin
                  st  <= S_FLUSH;
                  idx <= '0;
                end
              end else if (idx <= 7'd62) begin
                rsh <= {rsh[14:0], mdio_in};
              end else begin
                st      <= S_IDLE;
                done    <= 1'b1;
                rd_data <= rsh;
                err     <= 1'b0;
              end
            end
            S_FLUSH: if (idx == 7'd31) begin
              st      <= S_IDLE;
              done    <= 1'b1;
              rd_data <= 16'hFFFF;
              err     <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        done,
  input logic [15:0] rd_data,
  input logic        err,
  input logic        mdc,
  input logic        mdio_out,
  input logic        mdio_oe
);
  a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));

  a_r10_steady_while_high: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_oe) && $stable(mdio_out)));

  a_r12_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r11_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r12_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r8_fail_reads_ones: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (rd_data == 16'hFFFF));

  a_r12_results_held: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(rd_data) && $stable(err)));
endmodule

bind mdio_master mdio_master_chk chk_i (.*);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  localparam int H = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, req_c45 = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [20:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [31:0] ta_ignore_mask = 32'h0000_0080;
  logic        mdio_in = 1'b1;
  logic        busy, done, err, mdc, mdio_out, mdio_oe;
  logic [15:0] rd_data;

  mdio_master #(.HALF_CYC(H)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_c45(req_c45), .req_phy(req_phy), .req_addr(req_addr),
    .req_wdata(req_wdata), .ta_ignore_mask(ta_ignore_mask), .mdio_in(mdio_in),
    .busy(busy), .done(done), .rd_data(rd_data), .err(err), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  int vectors = 0;
  int fails = 0;
  bit [15:0] last_rd = '0;
  bit eoe[$];
  bit eo[$];
  bit din[$];
  string etag[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void push(input bit oe, input bit o, input bit di, input string t);
    eoe.push_back(oe); eo.push_back(o); din.push_back(di); etag.push_back(t);
  endfunction

  function automatic void hdr(input bit c45, input bit [1:0] op, input bit [4:0] phy,
                              input bit [4:0] regf, input string t);
    bit [13:0] h;
    for (int i = 0; i < 32; i++) push(1'b1, 1'b1, 1'b1, "R3");
    h = {(c45 ? 2'b00 : 2'b01), op, phy, regf};
    for (int i = 13; i >= 0; i--) push(1'b1, h[i], 1'b1, t);
  endfunction

  function automatic void wtail(input bit [15:0] d, input string t);
    push(1'b1, 1'b1, 1'b1, t);
    push(1'b1, 1'b0, 1'b1, t);
    for (int i = 15; i >= 0; i--) push(1'b1, d[i], 1'b1, t);
    push(1'b0, 1'b0, 1'b1, t);
  endfunction

  task automatic run(input bit wr, input bit c45, input bit [4:0] phy,
                     input bit [20:0] addr, input bit [15:0] wd, input bit ta,
                     input bit [15:0] pd, input bit spur);
    bit [4:0]  regf;
    bit [1:0]  op;
    bit [15:0] exp_rd;
    bit        exp_err, bad;
    string     ht, rt;
    eoe.delete(); eo.delete(); din.delete(); etag.delete();
    regf = c45 ? addr[20:16] : addr[4:0];
    ht = c45 ? "R6" : "R4";
    if (c45) begin
      hdr(1'b1, 2'b00, phy, regf, "R6");
      wtail(addr[15:0], "R6");
    end
    op = wr ? 2'b01 : (c45 ? 2'b11 : 2'b10);
    hdr(c45, op, phy, regf, ht);
    exp_rd = last_rd;
    exp_err = 1'b0;
    bad = !wr && ta && !ta_ignore_mask[phy];
    if (wr) begin
      wtail(wd, "R5");
      rt = "R5";
    end else begin
      push(1'b0, 1'b0, ta, "R7");
      if (bad) begin
        for (int i = 0; i < 32; i++) push(1'b0, 1'b0, 1'b1, "R8");
        exp_rd = 16'hFFFF;
        exp_err = 1'b1;
        rt = "R8";
      end else begin
        for (int i = 15; i >= 0; i--) push(1'b0, 1'b0, pd[i], "R7");
        push(1'b0, 1'b0, 1'b1, "R7");
        exp_rd = pd;
        rt = ta ? "R9" : "R7";
      end
    end
    req_write = wr; req_c45 = c45; req_phy = phy; req_addr = addr; req_wdata = wd;
    req_valid = 1'b1;
    for (int s = 0; s < eoe.size(); s++) begin
      for (int j = 0; j < 2 * H; j++) begin
        @(negedge clk);
        if (s == 0 && j == 0) req_valid = 1'b0;
        if (spur && s == 5 && j == 0) begin
          req_valid = 1'b1; req_phy = ~phy; req_write = ~wr; req_c45 = ~c45;
        end
        if (spur && s == 6 && j == 0) req_valid = 1'b0;
        if (j == 0) mdio_in = din[s];
        chk(mdc === (j >= H), "R2", "mdc", int'(mdc), int'(j >= H));
        chk(mdio_oe === eoe[s], {etag[s], "/R10"}, $sformatf("oe slot %0d", s),
            int'(mdio_oe), int'(eoe[s]));
        if (eoe[s])
          chk(mdio_out === eo[s], {etag[s], "/R10"}, $sformatf("out slot %0d", s),
              int'(mdio_out), int'(eo[s]));
        chk(busy === 1'b1 && done === 1'b0, "R11", "busy/done during transfer",
            int'({busy, done}), 2);
      end
    end
    mdio_in = 1'b1;
    req_valid = 1'b0;
    @(negedge clk);
    chk(done === 1'b1, "R12", "done pulse", int'(done), 1);
    chk(busy === 1'b0, "R11", "busy at completion", int'(busy), 0);
    chk(rd_data === exp_rd, rt, "rd_data", int'(rd_data), int'(exp_rd));
    chk(err === exp_err, rt, "err", int'(err), int'(exp_err));
    chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1", "idle bus", int'({mdc, mdio_oe}), 0);
    @(negedge clk);
    chk(done === 1'b0, "R12", "done width", int'(done), 0);
    chk(rd_data === exp_rd && err === exp_err, "R12", "results held",
        int'({err, rd_data}), int'({exp_err, exp_rd}));
    last_rd = exp_rd;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R11 actual=hung expected=complete");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!busy && !done && !mdc && !mdio_oe, "R1", "reset state",
          int'({busy, done, mdc, mdio_oe}), 0);
    end
    chk(rd_data === 16'h0 && err === 1'b0, "R1", "reset results", int'(rd_data), 0);
    run(1'b1, 1'b0, 5'd5,  21'h0000A, 16'hA5C3, 1'b0, 16'h0000, 1'b0);
    run(1'b0, 1'b0, 5'h11, 21'h0001F, 16'h0000, 1'b0, 16'h1234, 1'b0);
    run(1'b1, 1'b1, 5'd3,  {5'h1E, 16'hBEEF}, 16'h0F0F, 1'b0, 16'h0000, 1'b0);
    run(1'b0, 1'b1, 5'h1F, {5'h01, 16'h8001}, 16'h0000, 1'b0, 16'hC0DE, 1'b0);
    run(1'b0, 1'b0, 5'd2,  21'h00003, 16'h0000, 1'b1, 16'h0000, 1'b0);
    run(1'b0, 1'b0, 5'd7,  21'h00010, 16'h0000, 1'b1, 16'h5A5A, 1'b0);
    run(1'b1, 1'b0, 5'd9,  21'h00015, 16'h3C96, 1'b0, 16'h0000, 1'b1);
    run(1'b0, 1'b1, 5'd4,  {5'h07, 16'h0042}, 16'h0000, 1'b1, 16'h0000, 1'b1);
    run(1'b0, 1'b0, 5'd0,  21'h00001, 16'h0000, 1'b0, 16'h8001, 1'b0);
    repeat (3) @(negedge clk);
    chk(!busy && !mdc && !mdio_oe, "R1", "idle after runs", int'({busy, mdc, mdio_oe}), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule